// File: doc/BRIEF.md
# Buffered Gate-Interval Measurement Counter

This block measures pulse widths and periods of a gate signal, one interval after another. It counts rising edges of a count clock while a gate-defined interval is open. When the interval closes, it copies the count into a buffer register and clears the counter, so the next interval is measured with no gap. The first interval after enable starts from a host-supplied initial value. Every later interval starts from zero.

Both the gate and the count clock are sampled by a faster system clock. Each passes through a synchronizer and an edge detector, so all events are handled in a single clock domain. Six interval shapes can be selected:

- the time the gate is high;
- the time the gate is low;
- rising to falling edge;
- falling to rising edge;
- rising edge to rising edge;
- falling edge to falling edge.

The host reads the buffer by pulsing a read strobe. A valid flag shows that the buffer holds an unread value. An overrun flag shows that an unread value was replaced by a newer one. The counter never wraps: it stops at all-ones, and a value captured at all-ones carries a saturation mark.

Top module: `gate_interval_meter`

## Requirements
- R1: After reset, buf_o is 0 and buf_sat_o, buf_valid_o and overrun_o are all 0.
- R2: While en_i is low, the counter is held at init_i and no capture happens: gate and count-clock activity leave every output unchanged.
- R3: The first interval after en_i rises counts up from init_i. Every later interval counts up from 0. A capture loads the count into buf_o and clears the counter.
- R4: Mode code 0 (high-width) counts count-clock rising edges while the gate is high and captures on a gate falling edge. If the gate is already high when en_i rises, counting starts at once.
- R5: Mode code 1 (low-width) is the inverse of code 0. It counts while the gate is low and captures on a gate rising edge.
- R6: Mode codes 2 (rising-to-falling) and 3 (falling-to-rising) open an interval only on their opening edge. If the gate already sits at the open level when en_i rises, nothing is counted until the next opening edge. Count-clock edges between intervals are ignored.
- R7: Mode codes 4 (rising-to-rising) and 5 (falling-to-falling) are armed by the first edge of their polarity. Each later edge of that polarity captures a full period and immediately starts the next one.
- R8: buf_valid_o is set by every capture. A read strobe (rd_i high for one cycle) clears it when no capture falls in the same cycle.
- R9: A capture while buf_valid_o is set and rd_i is low sets overrun_o and overwrites buf_o with the newer value. A read clears overrun_o.
- R10: When a capture and a read fall in the same cycle, the read consumes the old value. The new value is loaded, buf_valid_o stays 1 and overrun_o stays 0.
- R11: The counter stops at all-ones instead of wrapping. buf_sat_o is 1 exactly when the captured value is all-ones.
- R12: Mode codes 6 and 7 are inert: no counting and no capture.
- R13: buf_o changes only on a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, faster than the count clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Measurement enable; low reloads the initial value |
| mode_i | input | 3 | Interval shape code (0 to 5; 6 and 7 inert) |
| init_i | input | CNT_W | Start value of the first interval |
| cnt_clk_i | input | 1 | Count clock; its rising edges are counted |
| gate_i | input | 1 | Gate signal that defines the intervals |
| rd_i | input | 1 | Read strobe; consumes the buffer |
| buf_o | output | CNT_W | Last captured count |
| buf_sat_o | output | 1 | Captured count reached all-ones |
| buf_valid_o | output | 1 | Buffer holds an unread value |
| overrun_o | output | 1 | An unread value was overwritten |

## Verification
A capture and a host read can land in the same system-clock cycle. In that cycle the read-side clear competes with the capture-side set of the valid and overrun flags. The bench provokes this case by counting the known synchronizer latency from a gate transition: it drives a gate falling edge in high-width mode and raises rd_i for exactly the cycle in which the capture registers. It then judges the result: buf_o must hold the new count, buf_valid_o must stay 1 and overrun_o must stay 0. A separate capture with no read checks that overrun_o does rise in that case.

// File: rtl/gim_pkg.sv
package gim_pkg;

  localparam logic [2:0] MODE_HIGH      = 3'd0;
  localparam logic [2:0] MODE_LOW       = 3'd1;
  localparam logic [2:0] MODE_RISE_FALL = 3'd2;
  localparam logic [2:0] MODE_FALL_RISE = 3'd3;
  localparam logic [2:0] MODE_RISE_RISE = 3'd4;
  localparam logic [2:0] MODE_FALL_FALL = 3'd5;

  typedef struct packed {
    logic ok;      // legal code
    logic inv;     // gate polarity inverted
    logic level;   // level-armed (counts at once if open)
    logic period;  // same-edge open and close
  } mode_dec_t;

  function automatic mode_dec_t decode_mode(logic [2:0] m);
    mode_dec_t d;
    d = '0;
    case (m)
      MODE_HIGH:      d = '{ok: 1'b1, inv: 1'b0, level: 1'b1, period: 1'b0};
      MODE_LOW:       d = '{ok: 1'b1, inv: 1'b1, level: 1'b1, period: 1'b0};
      MODE_RISE_FALL: d = '{ok: 1'b1, inv: 1'b0, level: 1'b0, period: 1'b0};
      MODE_FALL_RISE: d = '{ok: 1'b1, inv: 1'b1, level: 1'b0, period: 1'b0};
      MODE_RISE_RISE: d = '{ok: 1'b1, inv: 1'b0, level: 1'b0, period: 1'b1};
      MODE_FALL_FALL: d = '{ok: 1'b1, inv: 1'b1, level: 1'b0, period: 1'b1};
      default:        d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/gim_sync.sv
module gim_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign q_o = sync_q[STAGES-1];

endmodule

// File: rtl/gim_interval_ctrl.sv
module gim_interval_ctrl
  import gim_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [2:0] mode_i,
  input  logic       g_level_i,
  input  logic       g_rise_i,
  input  logic       g_fall_i,
  output logic       active_o,
  output logic       latch_o
);

  mode_dec_t dec;
  logic      run, lvl, open_ev, close_ev, active_q, active_d;

  assign dec      = decode_mode(mode_i);
  assign run      = en_i & dec.ok;
  assign lvl      = g_level_i ^ dec.inv;
  assign open_ev  = dec.inv ? g_fall_i : g_rise_i;
  assign close_ev = dec.inv ? g_rise_i : g_fall_i;

  // period shapes close on the opening edge
  assign latch_o = run & active_q & (dec.period ? open_ev : close_ev);

  always_comb begin
    if (!run)            active_d = 1'b0;
    else if (dec.level)  active_d = lvl;
    else if (dec.period) active_d = active_q | open_ev;
    else if (open_ev)    active_d = 1'b1;
    else if (close_ev)   active_d = 1'b0;
    else                 active_d = active_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_q <= 1'b0;
    else         active_q <= active_d;
  end

  assign active_o = active_q;

endmodule

// File: rtl/gim_counter.sv
module gim_counter #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] init_i,
  input  logic         step_i,
  input  logic         clear_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (!en_i)                       cnt_q <= init_i;
    else if (clear_i)                     cnt_q <= '0;
    else if (step_i && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/gim_capture.sv
module gim_capture #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         latch_i,
  input  logic [W-1:0] cnt_i,
  input  logic         rd_i,
  output logic [W-1:0] buf_o,
  output logic         sat_o,
  output logic         valid_o,
  output logic         overrun_o
);

  logic [W-1:0] buf_q;
  logic         sat_q, valid_q, ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q   <= '0;
      sat_q   <= 1'b0;
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else if (latch_i) begin
      buf_q   <= cnt_i;
      sat_q   <= &cnt_i;
      valid_q <= 1'b1;
      // a read in the same cycle consumes the old value
      ovr_q   <= rd_i ? 1'b0 : (ovr_q | valid_q);
    end else if (rd_i) begin
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
    end
  end

  assign buf_o     = buf_q;
  assign sat_o     = sat_q;
  assign valid_o   = valid_q;
  assign overrun_o = ovr_q;

endmodule

// File: rtl/gate_interval_meter.sv
module gate_interval_meter #(
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [2:0]       mode_i,
  input  logic [CNT_W-1:0] init_i,
  input  logic             cnt_clk_i,
  input  logic             gate_i,
  input  logic             rd_i,
  output logic [CNT_W-1:0] buf_o,
  output logic             buf_sat_o,
  output logic             buf_valid_o,
  output logic             overrun_o
);

  logic             g_lvl, c_lvl, g_prev_q, c_prev_q;
  logic             g_rise, g_fall, c_tick;
  logic             active_w, latch_w;
  logic [CNT_W-1:0] cnt_w;

  gim_sync #(.STAGES(SYNC_STAGES)) i_gate_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(gate_i), .q_o(g_lvl)
  );

  gim_sync #(.STAGES(SYNC_STAGES)) i_cclk_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cnt_clk_i), .q_o(c_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      g_prev_q <= 1'b0;
      c_prev_q <= 1'b0;
    end else begin
      g_prev_q <= g_lvl;
      c_prev_q <= c_lvl;
    end
  end

  assign g_rise = g_lvl & ~g_prev_q;
  assign g_fall = ~g_lvl & g_prev_q;
  assign c_tick = c_lvl & ~c_prev_q;

  gim_interval_ctrl i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .mode_i   (mode_i),
    .g_level_i(g_lvl),
    .g_rise_i (g_rise),
    .g_fall_i (g_fall),
    .active_o (active_w),
    .latch_o  (latch_w)
  );

  gim_counter #(.W(CNT_W)) i_counter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .init_i (init_i),
    .step_i (active_w & c_tick),
    .clear_i(latch_w),
    .cnt_o  (cnt_w)
  );

  gim_capture #(.W(CNT_W)) i_capture (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .latch_i  (latch_w),
    .cnt_i    (cnt_w),
    .rd_i     (rd_i),
    .buf_o    (buf_o),
    .sat_o    (buf_sat_o),
    .valid_o  (buf_valid_o),
    .overrun_o(overrun_o)
  );

endmodule

// File: rtl/gim_checker.sv
module gim_checker #(
  parameter int W = 24
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         en_i,
  input logic         rd_i,
  input logic         latch,
  input logic [W-1:0] cnt,
  input logic [W-1:0] buf_o,
  input logic         buf_valid_o,
  input logic         overrun_o
);

  assert_disabled_no_latch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !latch);

  assert_clear_after_latch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch |=> cnt == '0);

  assert_valid_on_latch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch |=> buf_valid_o);

  assert_read_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_valid_o && rd_i && !latch) |=> !buf_valid_o);

  assert_overrun_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !$past(overrun_o)) |-> ($past(latch) && $past(buf_valid_o) && !$past(rd_i)));

  assert_no_overrun_on_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch && rd_i) |=> (buf_valid_o && !overrun_o));

  assert_no_wrap_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !latch) |=> cnt >= $past(cnt));

  assert_buf_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch |=> $stable(buf_o));

endmodule

bind gate_interval_meter gim_checker #(.W(CNT_W)) i_gim_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .rd_i       (rd_i),
  .latch      (latch_w),
  .cnt        (cnt_w),
  .buf_o      (buf_o),
  .buf_valid_o(buf_valid_o),
  .overrun_o  (overrun_o)
);

// File: tb/test_gate_interval_meter.sv
module test_gate_interval_meter;

  localparam int W = 24;
  localparam logic [W-1:0] MAXV = '1;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         en_i = 1'b0;
  logic [2:0]   mode_i = 3'd0;
  logic [W-1:0] init_i = '0;
  logic         cnt_clk_i = 1'b0;
  logic         gate_i = 1'b0;
  logic         rd_i = 1'b0;
  logic [W-1:0] buf_o;
  logic         buf_sat_o, buf_valid_o, overrun_o;

  int  n_run = 0;
  int  n_fail = 0;
  bit  done = 0;
  logic inv = 1'b0;

  gate_interval_meter #(.CNT_W(W), .SYNC_STAGES(2)) i_gate_interval_meter (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .mode_i(mode_i), .init_i(init_i),
    .cnt_clk_i(cnt_clk_i), .gate_i(gate_i), .rd_i(rd_i), .buf_o(buf_o),
    .buf_sat_o(buf_sat_o), .buf_valid_o(buf_valid_o), .overrun_o(overrun_o)
  );

  always #5 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      cnt_clk_i = 1'b1; idle(3);
      cnt_clk_i = 1'b0; idle(3);
    end
  endtask

  // drive the mode-relative gate level (inverted for odd codes)
  task automatic set_g(input logic v);
    gate_i = v ^ inv;
    idle(6);
  endtask

  task automatic rd_pulse();
    rd_i = 1'b1; idle(1);
    rd_i = 1'b0; idle(1);
  endtask

  task automatic setup(input logic [2:0] m, input logic [W-1:0] iv, input logic g_open);
    en_i = 1'b0; idle(1);
    if (buf_valid_o) rd_pulse();
    mode_i = m; init_i = iv; inv = m[0];
    gate_i = g_open ^ inv;
    idle(6);
    en_i = 1'b1; idle(2);
  endtask

  task automatic chk_buf(input string req, input logic [W-1:0] exp);
    chk(req, {8'h0, buf_o}, {8'h0, exp});
    chk(req, 32'(buf_valid_o), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int nlist[4];
    logic [W-1:0] iv, keep;
    nlist = '{0, 1, 3, 6};
    idle(3);
    // R1 reset state
    chk("R1 buf", {8'h0, buf_o}, 32'd0);
    chk("R1 sat", 32'(buf_sat_o), 32'd0);
    chk("R1 valid", 32'(buf_valid_o), 32'd0);
    chk("R1 overrun", 32'(overrun_o), 32'd0);
    rst_ni = 1'b1; idle(2);

    // sweep of all shapes and counts
    for (int m = 0; m < 6; m++) begin
      for (int k = 0; k < 4; k++) begin
        int n1, n2;
        n1 = nlist[k];
        n2 = (n1 + 2) % 5;
        iv = W'(32'h100 * m + 32'h10 * k + 5);
        setup(3'(m), iv, 1'b0);
        set_g(1'b1);
        pulses(n1);
        set_g(1'b0);
        if (m >= 4) begin
          // R7: first rise only arms, period spans both levels
          pulses(2);
          set_g(1'b1);
          chk_buf("R7 first period from init (R3)", iv + W'(n1 + 2));
          chk("R11 no sat", 32'(buf_sat_o), 32'd0);
          rd_pulse();
          chk("R8 read clears", 32'(buf_valid_o), 32'd0);
          pulses(n2);
          set_g(1'b0);
          pulses(1);
          set_g(1'b1);
          chk_buf("R7 later period from 0 (R3)", W'(n2 + 1));
        end else begin
          chk_buf((m < 2) ? "R4/R5 first width from init (R3)" : "R6 first width from init (R3)",
                  iv + W'(n1));
          chk("R11 no sat", 32'(buf_sat_o), 32'd0);
          rd_pulse();
          chk("R8 read clears", 32'(buf_valid_o), 32'd0);
          pulses(2);  // outside interval: ignored
          set_g(1'b1);
          pulses(n2);
          set_g(1'b0);
          chk_buf((m < 2) ? "R4/R5 later width from 0 (R3)" : "R6 later width from 0 (R3)",
                  W'(n2));
        end
        chk("R9 no overrun", 32'(overrun_o), 32'd0);
      end
    end

    // level-armed vs edge-armed start with gate already open
    for (int m = 0; m < 4; m++) begin
      iv = W'(32'h40 + m);
      setup(3'(m), iv, 1'b1);
      pulses(2);
      set_g(1'b0);
      if (m < 2) begin
        chk_buf("R4 level mode counts at once", iv + W'(2));
        rd_pulse();
      end else begin
        chk("R6 edge mode waits for opening edge", 32'(buf_valid_o), 32'd0);
      end
      set_g(1'b1);
      pulses(3);
      set_g(1'b0);
      chk_buf("R6 next interval", (m < 2) ? W'(3) : iv + W'(3));
    end

    // R2: disabled block ignores gate and count clock
    rd_pulse();
    keep = buf_o;
    en_i = 1'b0; mode_i = 3'd4; idle(2);
    for (int i = 0; i < 3; i++) begin
      gate_i = 1'b1; idle(6); pulses(2); gate_i = 1'b0; idle(6);
    end
    chk("R2 no capture while disabled", 32'(buf_valid_o), 32'd0);
    chk("R2 buffer unchanged (R13)", {8'h0, buf_o}, {8'h0, keep});

    // R12: inert codes
    for (int m = 6; m < 8; m++) begin
      setup(3'(m), W'(7), 1'b0);
      for (int i = 0; i < 3; i++) begin
        gate_i = 1'b1; idle(6); pulses(2); gate_i = 1'b0; idle(6); pulses(1);
      end
      chk("R12 inert code no capture", 32'(buf_valid_o), 32'd0);
      chk("R12 buffer unchanged", {8'h0, buf_o}, {8'h0, keep});
    end

    // R9: overrun on unread capture
    setup(3'd0, W'(10), 1'b0);
    set_g(1'b1); pulses(1); set_g(1'b0);
    chk_buf("R9 first capture", W'(11));
    chk("R9 no overrun yet", 32'(overrun_o), 32'd0);
    set_g(1'b1); pulses(2); set_g(1'b0);
    chk_buf("R9 newest value kept", W'(2));
    chk("R9 overrun set", 32'(overrun_o), 32'd1);
    rd_pulse();
    chk("R9 read clears valid", 32'(buf_valid_o), 32'd0);
    chk("R9 read clears overrun", 32'(overrun_o), 32'd0);

    // R10: capture and read in the same cycle
    setup(3'd0, W'(0), 1'b0);
    set_g(1'b1); pulses(1); set_g(1'b0);
    chk_buf("R10 setup capture", W'(1));
    set_g(1'b1); pulses(4);
    gate_i = 1'b0;       // sampled by 1st edge, capture at 3rd edge
    idle(2);
    rd_i = 1'b1; idle(1);
    rd_i = 1'b0; idle(4);
    chk_buf("R10 new value valid after coincident read", W'(4));
    chk("R10 no overrun", 32'(overrun_o), 32'd0);

    // R11: saturation
    setup(3'd0, MAXV - W'(2), 1'b0);
    set_g(1'b1); pulses(5); set_g(1'b0);
    chk_buf("R11 saturated value", MAXV);
    chk("R11 sat flag", 32'(buf_sat_o), 32'd1);
    rd_pulse();
    set_g(1'b1); pulses(2); set_g(1'b0);
    chk_buf("R11 after saturation", W'(2));
    chk("R11 sat flag clear", 32'(buf_sat_o), 32'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule